// File: doc/BRIEF.md
# Clock Root Generator with Commit Handshake

This block forms the root of a clock tree. It selects one of several source clocks and divides the selected source by a programmable ratio. Each source is presented in the reference clock domain as a tick input, which pulses once for each source edge, together with a running flag. The divided result leaves the block as a one-cycle clock-enable pulse, `clk_en_out`.

Software programs a staged source and divider through a small register port. The staged setting has no effect until software raises an update request. The request bit then reads as 1 until the block has adopted the new setting, and it clears itself at that point. The block changes over only when the target source is running, and only on a boundary of the divided output, so the output never carries a short period.

A parameter chooses between two register layouts. In the split layout, the request bit sits in a command word of its own. In the shared layout, the request sits in the configuration word itself.

Top module: `clkroot_gen`

## Requirements
- R1: After reset, the staged and active source and divider are all 0, no update is pending, and `clk_en_out` pulses once per tick of source 0.
- R2: A divider field value F divides by N = F[4:1] + 1, so 2N-1 gives N and 0 passes the source through. `clk_en_out` pulses once every N ticks of the active source.
- R3: Split layout. Word 1 holds the source select in bits 10:8 and the divider in bits 4:0. Word 0 bit 0 is the update request, and writing 1 to it starts an update.
- R4: Shared layout. Word 0 holds the source select in bits 2:0, the divider in bits 7:3, a stored enable bit 10, and the request bit 11. An update starts only when one write sets both bit 11 and bit 10. Bit 11 alone does nothing.
- R5: Writing the configuration fields without a request leaves the active setting and the output unchanged.
- R6: From the cycle after the request, the request bit reads 1. It clears by itself in the cycle that the staged setting becomes active.
- R7: The changeover waits until the target source reports running. Source 0 always counts as running.
- R8: The changeover happens in the same cycle as an output pulse of the old setting, and the division count restarts. If the current source is not running, the changeover happens as soon as the target runs.
- R9: While an update is pending, writes to the configuration fields are ignored, and no write can clear the request bit.
- R10: A source select at or above the number of sources is stored as 0. Unmapped word addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| src_tick | input | NUM_SRC | One pulse per edge of each source |
| src_ok | input | NUM_SRC | Source running flags (bit 0 ignored) |
| clk_en_out | output | 1 | Divided clock-enable pulse |
| active_sel | output | 3 | Source currently in use |
| active_div | output | 5 | Divider field currently in use |

## Verification
The assertions take for granted that `src_ok` and `src_tick` change only between clock edges. They also assume that the register port presents at most one write per cycle. The stimulus drives all of these on the falling edge, from a single generator of periodic source ticks. It lowers a running flag only while the affected source is either the target of a pending update or the current source that is being abandoned. It raises that flag again before the next scenario, so every update eventually completes.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    localparam int SEL_W  = 3;
    localparam int DIV_W  = 5;
    localparam int DATA_W = 32;

    typedef enum logic {
        LAYOUT_SPLIT  = 1'b0,
        LAYOUT_SHARED = 1'b1
    } layout_e;

    // Field positions for the split layout
    localparam int SPLIT_SEL_LSB  = 8;
    localparam int SPLIT_DIV_LSB  = 0;
    localparam int SPLIT_REQ_BIT  = 0;

    // Field positions for the shared layout
    localparam int SHARED_SEL_LSB = 0;
    localparam int SHARED_DIV_LSB = 3;
    localparam int SHARED_ENA_BIT = 10;
    localparam int SHARED_REQ_BIT = 11;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } root_cfg_t;

    // Terminal count for a half-step divider field: N-1 = F[4:1]
    function automatic logic [DIV_W-2:0] div_terminal(input logic [DIV_W-1:0] f);
        return f[DIV_W-1:1];
    endfunction

    function automatic int sel_lsb(input layout_e l);
        return (l == LAYOUT_SPLIT) ? SPLIT_SEL_LSB : SHARED_SEL_LSB;
    endfunction

    function automatic int div_lsb(input layout_e l);
        return (l == LAYOUT_SPLIT) ? SPLIT_DIV_LSB : SHARED_DIV_LSB;
    endfunction

endpackage

// File: rtl/clkroot_regs.sv
module clkroot_regs
    import clkroot_pkg::*;
#(
    parameter layout_e LAYOUT  = LAYOUT_SPLIT,
    parameter int      NUM_SRC = 3,
    parameter int      ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] rdata,
    output root_cfg_t         staged,
    output logic              pending
);

    localparam int SEL_LSB = sel_lsb(LAYOUT);
    localparam int DIV_LSB = div_lsb(LAYOUT);
    localparam logic [ADDR_W-1:0] CMD_ADDR = '0;
    localparam logic [ADDR_W-1:0] CFG_ADDR = (LAYOUT == LAYOUT_SPLIT) ? ADDR_W'(1) : '0;
    localparam logic [SEL_W-1:0]  NSRC_L   = SEL_W'(NUM_SRC);

    logic             cfg_hit;
    logic             req_set;
    logic [SEL_W-1:0] wr_sel;
    root_cfg_t        wr_cfg;

    assign cfg_hit    = we && (addr == CFG_ADDR) && !pending;
    assign wr_sel     = wdata[SEL_LSB +: SEL_W];
    assign wr_cfg.sel = (wr_sel < NSRC_L) ? wr_sel : '0;
    assign wr_cfg.div = wdata[DIV_LSB +: DIV_W];

    generate
        if (LAYOUT == LAYOUT_SPLIT) begin : g_split
            assign req_set = we && (addr == CMD_ADDR) && wdata[SPLIT_REQ_BIT] && !pending;

            always_comb begin
                rdata = '0;
                if (addr == CMD_ADDR) begin
                    rdata[SPLIT_REQ_BIT] = pending;
                end else if (addr == CFG_ADDR) begin
                    rdata[SEL_LSB +: SEL_W] = staged.sel;
                    rdata[DIV_LSB +: DIV_W] = staged.div;
                end
            end
        end else begin : g_shared
            logic ena_q;

            assign req_set = cfg_hit && wdata[SHARED_REQ_BIT] && wdata[SHARED_ENA_BIT];

            always_ff @(posedge clk) begin
                if (rst) begin
                    ena_q <= 1'b0;
                end else if (cfg_hit) begin
                    ena_q <= wdata[SHARED_ENA_BIT];
                end
            end

            always_comb begin
                rdata = '0;
                if (addr == CFG_ADDR) begin
                    rdata[SEL_LSB +: SEL_W]  = staged.sel;
                    rdata[DIV_LSB +: DIV_W]  = staged.div;
                    rdata[SHARED_ENA_BIT]    = ena_q;
                    rdata[SHARED_REQ_BIT]    = pending;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (commit) begin
            pending <= 1'b0;
        end else if (req_set) begin
            pending <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (cfg_hit) begin
            staged <= wr_cfg;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

endmodule

// File: rtl/clkroot_switch.sv
module clkroot_switch
    import clkroot_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  root_cfg_t          staged,
    input  logic               pending,
    input  logic [NUM_SRC-1:0] src_ok,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wrap,
    output root_cfg_t          active,
    output logic               cur_tick,
    output logic               commit
);

    logic [NUM_SRC-1:0] run_eff;
    logic               tgt_live;
    logic               cur_live;

    // Source 0 is the free-running reference and always counts as running
    assign run_eff = {src_ok[NUM_SRC-1:1], 1'b1};

    always_comb begin
        tgt_live = 1'b0;
        cur_live = 1'b0;
        cur_tick = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (staged.sel == SEL_W'(k)) tgt_live = run_eff[k];
            if (active.sel == SEL_W'(k)) begin
                cur_live = run_eff[k];
                cur_tick = src_tick[k];
            end
        end
    end

    // Change over on an output boundary, or at once if the old source stalled
    assign commit = pending && tgt_live && (wrap || !cur_live);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (commit) begin
            active <= staged;
        end
    end

    logic unused_ok0;
    assign unused_ok0 = src_ok[0];

endmodule

// File: rtl/clkroot_div.sv
module clkroot_div
    import clkroot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_field,
    input  logic             load,
    output logic             wrap,
    output logic             ce
);

    logic [DIV_W-2:0] cnt;

    assign wrap = tick && (cnt == div_terminal(div_field));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ce  <= 1'b0;
        end else begin
            ce <= wrap;
            if (load || wrap) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    logic unused_lsb;
    assign unused_lsb = div_field[0];

endmodule

// File: rtl/clkroot_gen.sv
module clkroot_gen
    import clkroot_pkg::*;
#(
    parameter layout_e LAYOUT  = LAYOUT_SPLIT,
    parameter int      NUM_SRC = 3,
    parameter int      ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [NUM_SRC-1:0] src_ok,
    output logic               clk_en_out,
    output logic [SEL_W-1:0]   active_sel,
    output logic [DIV_W-1:0]   active_div
);

    root_cfg_t staged;
    root_cfg_t active;
    logic      upd_pending;
    logic      commit;
    logic      wrap;
    logic      cur_tick;

    clkroot_regs #(
        .LAYOUT (LAYOUT),
        .NUM_SRC(NUM_SRC),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .commit (commit),
        .rdata  (reg_rdata),
        .staged (staged),
        .pending(upd_pending)
    );

    clkroot_switch #(
        .NUM_SRC(NUM_SRC)
    ) u_switch (
        .clk     (clk),
        .rst     (rst),
        .staged  (staged),
        .pending (upd_pending),
        .src_ok  (src_ok),
        .src_tick(src_tick),
        .wrap    (wrap),
        .active  (active),
        .cur_tick(cur_tick),
        .commit  (commit)
    );

    clkroot_div u_div (
        .clk      (clk),
        .rst      (rst),
        .tick     (cur_tick),
        .div_field(active.div),
        .load     (commit),
        .wrap     (wrap),
        .ce       (clk_en_out)
    );

    assign active_sel = active.sel;
    assign active_div = active.div;

endmodule

// File: rtl/clkroot_gen_chk.sv
module clkroot_gen_chk
    import clkroot_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               upd_pending,
    input logic [SEL_W-1:0]   stg_sel,
    input logic [DIV_W-1:0]   stg_div,
    input logic [SEL_W-1:0]   act_sel,
    input logic [DIV_W-1:0]   act_div,
    input logic [NUM_SRC-1:0] src_ok,
    input logic               clk_en_out
);

    localparam logic [SEL_W-1:0] NSRC_L = SEL_W'(NUM_SRC);

    logic tgt_live;
    logic cur_live;

    always_comb begin
        tgt_live = 1'b0;
        cur_live = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (stg_sel == SEL_W'(k)) tgt_live = (k == 0) ? 1'b1 : src_ok[k];
            if (act_sel == SEL_W'(k)) cur_live = (k == 0) ? 1'b1 : src_ok[k];
        end
    end

    // R5: without a pending request the active setting never moves
    a_r5_hold_without_request: assert property (@(posedge clk) disable iff (rst)
        !$past(upd_pending) |-> ($stable(act_sel) && $stable(act_div)));

    // R9: staged fields are frozen while a request is pending
    a_r9_fields_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(upd_pending) |-> ($stable(stg_sel) && $stable(stg_div)));

    // R6: the request clears exactly when the staged setting is active
    a_r6_clear_on_adopt: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pending) |-> (act_sel == stg_sel && act_div == stg_div));

    // R7: completion only with a running target
    a_r7_target_running: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pending) |-> $past(tgt_live));

    // R8: a change of setting lands on an output pulse unless the old source stalled
    a_r8_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$stable(act_sel) || !$stable(act_div)) |-> (clk_en_out || !$past(cur_live)));

    // R10: staged select is always a real source
    a_r10_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        stg_sel < NSRC_L);

endmodule

bind clkroot_gen clkroot_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_pending(upd_pending),
    .stg_sel    (staged.sel),
    .stg_div    (staged.div),
    .act_sel    (active.sel),
    .act_div    (active.div),
    .src_ok     (src_ok),
    .clk_en_out (clk_en_out)
);

// File: tb/clkroot_gen_test.sv
module clkroot_gen_test;
    import clkroot_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int P0 = 2;
    localparam int P1 = 1;
    localparam int P2 = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we_a = 1'b0;
    logic        we_b = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [2:0]  src_tick = '0;
    logic [2:0]  src_ok = 3'b111;
    logic        ce_a, ce_b;
    logic [2:0]  sel_a, sel_b;
    logic [4:0]  div_a, div_b;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    clkroot_gen uut (
        .clk(clk), .rst(rst), .reg_we(we_a), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata_a), .src_tick(src_tick), .src_ok(src_ok),
        .clk_en_out(ce_a), .active_sel(sel_a), .active_div(div_a)
    );

    clkroot_gen #(.LAYOUT(LAYOUT_SHARED)) uut_b (
        .clk(clk), .rst(rst), .reg_we(we_b), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata_b), .src_tick(src_tick), .src_ok(src_ok),
        .clk_en_out(ce_b), .active_sel(sel_b), .active_div(div_b)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // periodic source ticks, driven on the falling edge
    initial begin
        int c0, c1, c2;
        c0 = 0; c1 = 0; c2 = 0;
        forever begin
            @(negedge clk);
            src_tick[0] = (c0 == P0-1);
            src_tick[1] = (c1 == P1-1);
            src_tick[2] = (c2 == P2-1);
            c0 = (c0 == P0-1) ? 0 : c0 + 1;
            c1 = (c1 == P1-1) ? 0 : c1 + 1;
            c2 = (c2 == P2-1) ? 0 : c2 + 1;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a;
        wdata = d;
        if (b) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
    endtask

    task automatic peek(input bit b, input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = b ? rdata_b : rdata_a;
    endtask

    task automatic rd(input bit b, input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        peek(b, a, v);
    endtask

    // poll the request bit until it clears; returns cycles waited
    task automatic poll(input bit b, input int limit, output int waited);
        logic [31:0] v;
        waited = 0;
        do begin
            rd(b, 2'd0, v);
            waited++;
        end while ((b ? v[11] : v[0]) && waited < limit);
    endtask

    task automatic wait_pulse(input bit b);
        int g = 0;
        while ((b ? ce_b : ce_a) !== 1'b1 && g < 500) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic interval(input bit b, output int iv);
        int t0;
        @(negedge clk);
        wait_pulse(b);
        t0 = cyc;
        @(negedge clk);
        wait_pulse(b);
        iv = cyc - t0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        int iv;
        rd(0, 2'd0, v); check("R1 split cmd after reset", v, 0);
        rd(0, 2'd1, v); check("R1 split cfg after reset", v, 0);
        rd(1, 2'd0, v); check("R1 shared cfg after reset", v, 0);
        check("R1 active sel", sel_a, 0);
        check("R1 active div", div_a, 0);
        interval(0, iv); check("R1 source 0 passthrough interval", iv, P0);
    endtask

    task automatic t_shared_layout;
        logic [31:0] v;
        int w, iv;
        wr(1, 2'd0, 32'h829);
        repeat (10) @(negedge clk);
        peek(1, 2'd0, v); check("R4 bit 11 alone starts nothing", v, 32'h029);
        check("R4 active unchanged", sel_b, 0);
        wr(1, 2'd0, 32'hC29);
        peek(1, 2'd0, v); check("R4 request pending with enable", v, 32'hC29);
        poll(1, 64, w); check("R4 request completes", (w < 64) ? 1 : 0, 1);
        peek(1, 2'd0, v); check("R4 bit 11 clear, bit 10 kept", v, 32'h429);
        check("R4 active sel", sel_b, 1);
        check("R4 active div", div_b, 5);
        interval(1, iv); check("R2 shared divide by 3", iv, 3 * P1);
    endtask

    task automatic t_stage_only;
        logic [31:0] v;
        int iv;
        wr(0, 2'd1, 32'h103);
        repeat (20) @(negedge clk);
        check("R5 active sel after field write", sel_a, 0);
        check("R5 active div after field write", div_a, 0);
        peek(0, 2'd1, v); check("R3 cfg readback", v, 32'h103);
        interval(0, iv); check("R5 output unchanged", iv, P0);
    endtask

    task automatic t_commit;
        logic [31:0] v;
        int iv;
        bit seen = 0;
        wr(0, 2'd0, 32'h1);
        peek(0, 2'd0, v); check("R6 request reads 1", v, 1);
        for (int i = 0; i < 64 && !seen; i++) begin
            @(negedge clk);
            if (sel_a != 0) begin
                seen = 1;
                check("R8 changeover on output pulse", ce_a, 1);
            end
        end
        check("R3 commit took effect", seen, 1);
        peek(0, 2'd0, v); check("R6 request self-cleared", v, 0);
        check("R6 active div", div_a, 3);
        interval(0, iv); check("R2 divide by 2", iv, 2 * P1);
    endtask

    task automatic t_wait_src;
        logic [31:0] v;
        int w, iv;
        src_ok[2] = 1'b0;
        wr(0, 2'd1, 32'h200);
        wr(0, 2'd0, 32'h1);
        repeat (30) @(negedge clk);
        peek(0, 2'd0, v); check("R7 waits for stopped target", v, 1);
        check("R7 active still old", sel_a, 1);
        wr(0, 2'd1, 32'h005);
        peek(0, 2'd1, v); check("R9 field write ignored", v, 32'h200);
        wr(0, 2'd0, 32'h0);
        peek(0, 2'd0, v); check("R9 request not cleared by write", v, 1);
        @(negedge clk);
        src_ok[2] = 1'b1;
        poll(0, 16, w); check("R7 completes once running", (w < 16) ? 1 : 0, 1);
        check("R7 active sel", sel_a, 2);
        interval(0, iv); check("R2 source 2 passthrough", iv, P2);
    endtask

    task automatic t_dead_src;
        logic [31:0] v;
        int w, iv;
        @(negedge clk);
        src_ok[2] = 1'b0;
        wr(0, 2'd1, 32'h001);
        wr(0, 2'd0, 32'h1);
        peek(0, 2'd0, v); check("R8 request set", v, 1);
        poll(0, 8, w); check("R8 immediate change from stalled source", w, 1);
        check("R8 active sel", sel_a, 0);
        src_ok[2] = 1'b1;
        interval(0, iv); check("R2 field 1 divides by 1", iv, P0);
    endtask

    task automatic t_large_div;
        int w, iv;
        wr(0, 2'd1, 32'h009);
        wr(0, 2'd0, 32'h1);
        poll(0, 64, w);
        interval(0, iv); check("R2 field 9 divides by 5", iv, 5 * P0);
        wr(0, 2'd1, 32'h01F);
        wr(0, 2'd0, 32'h1);
        poll(0, 64, w);
        check("R2 field 31 active", div_a, 31);
        interval(0, iv); check("R2 field 31 divides by 16", iv, 16 * P0);
    endtask

    task automatic t_range;
        logic [31:0] v;
        wr(0, 2'd1, 32'h507);
        peek(0, 2'd1, v); check("R10 out-of-range select stored as 0", v, 32'h007);
        wr(0, 2'd2, 32'hFFFF_FFFF);
        peek(0, 2'd2, v); check("R10 unmapped word reads 0", v, 0);
        rd(0, 2'd3, v); check("R10 unmapped word 3 reads 0", v, 0);
        rd(0, 2'd1, v); check("R10 unmapped write ignored", v, 32'h007);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1-all actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shared_layout();
        t_stage_only();
        t_commit();
        t_wait_src();
        t_dead_src();
        t_large_div();
        t_range();
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule